// File: doc/BRIEF.md
# RS-485 UART Transmitter with Direction Control

This block is the send half of a serial port meant for a half-duplex RS-485 bus. The host writes characters into a 64-entry queue. A shifter takes them one by one and sends each as a 10-bit frame on an idle-high line: a low start bit, eight data bits with the least significant bit first, and a high stop bit. No parity bit is sent. The length of each bit, in clock cycles, is set by an input.

The block drives the transceiver's driver-enable pin itself. It raises the pin before the first start bit of a message and keeps it high until the last stop bit has fully left the shifter. Software does not have to poll for the end of transmission. Two programmable guard intervals can stretch the time before the first start bit and the time after the last stop bit. A write that arrives during the trailing interval cancels the release, and the next frame follows while the bus is still held.

A level-sensitive transmit-request interrupt works in one of two modes. In threshold mode it asks for more data while the queue is at most half full. In drained mode it signals only once the queue and the shifter are both empty. A status bit reports that the last character has completed.

Top module: `rs485_uart_tx`

## Requirements
- R1: Reset state: `txd` is 1, `dir_en` is 0, `tx_done` is 1, `fifo_level` is 0 and `overflow` is 0.
- R2: Each frame is a 0 start bit, eight data bits LSB first, and a 1 stop bit. Every bit lasts `bit_cycles` clocks, and a value of 0 is treated as 1.
- R3: The queue holds 64 characters and `fifo_level` reports the count. A write while the level is 64 is discarded and sets `overflow`, which stays 1 until reset.
- R4: A character leaves the queue at the clock edge where its start bit begins, so the level drops by one. While characters remain, frames follow one another with no idle cycle between them, and the direction pin is released only once per message.
- R5: With `empty_irq_mode`=0, the raw request is high whenever `fifo_level` is 32 or less.
- R6: With `empty_irq_mode`=1, the raw request is high only when the queue holds nothing and no frame is being shifted.
- R7: `irq` equals `irq_enable` AND the raw request. A change of mode or enable shows on `irq` in the same cycle; clearing the mode with 32 or fewer queued characters raises `irq` at once.
- R8: `dir_en` rises exactly `lead_delay`+1 clocks before the first start bit of a message.
- R9: `dir_en` falls exactly `trail_delay`+1 clocks after the stop bit of the final frame ends. `txd` is never 0 while `dir_en` is 0.
- R10: A write during the trailing interval keeps `dir_en` high, and the new character is sent without the pin being released.
- R11: `tx_done` becomes 1 when a stop bit completes with the queue empty, and is 0 from the clock after any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | 8 | Character to queue |
| wr_en | input | 1 | Write strobe for `wr_data` |
| fifo_level | output | 7 | Number of queued characters (0 to 64) |
| overflow | output | 1 | Sticky flag: a write to a full queue was dropped |
| bit_cycles | input | 16 | Clocks per serial bit (0 acts as 1) |
| lead_delay | input | 16 | Extra clocks between enabling the driver and the first start bit |
| trail_delay | input | 16 | Extra clocks between the last stop bit and releasing the driver |
| empty_irq_mode | input | 1 | 0: request on threshold, 1: request when fully drained |
| irq_enable | input | 1 | Interrupt enable |
| irq | output | 1 | Level transmit-request interrupt |
| tx_done | output | 1 | Last character fully sent |
| txd | output | 1 | Serial data, idle high |
| dir_en | output | 1 | RS-485 driver enable |

## Verification
The bench sweeps zero, one and three clocks per bit against both zero and nonzero guard intervals. It measures the exact clock distance from driver enable to start bit and from stop bit to release. A design off by one in either counter, or one that drops the pin one bit time early, shows up as a wrong distance. Back-to-back bursts catch an idle cycle between frames or an early release. A 70-write flood catches a queue that overwrites or wraps instead of dropping the extra characters. A write during the trailing interval catches a design that releases the bus before sending again. The interrupt is checked every cycle against the bench's own threshold and drained-state model, so a swapped mode, a wrong threshold, or a request that ignores the character still in the shifter is reported.

// File: rtl/rs485tx_pkg.sv
package rs485tx_pkg;

  typedef enum logic [1:0] {
    DIR_IDLE,
    DIR_LEAD,
    DIR_RUN,
    DIR_TRAIL
  } dir_state_e;

  // Raw transmit-request: drained mode needs queue and shifter empty,
  // threshold mode needs the queue at or under its threshold.
  function automatic logic irq_request(logic drained_mode, logic queue_empty,
                                       logic under_thresh, logic shifting);
    return drained_mode ? (queue_empty && !shifting) : under_thresh;
  endfunction

  // Last cycle index of one bit period; a zero setting means one clock.
  function automatic logic [15:0] last_bit_cycle(logic [15:0] setting);
    return (setting == 16'd0) ? 16'd0 : setting - 16'd1;
  endfunction

endpackage

// File: rtl/rs485tx_fifo.sv
module rs485tx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [LVL_W-1:0]  level,
  output logic              dropped
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              full, push;

  assign full = (level == LVL_W'(DEPTH));
  assign push = push_req && !full;
  assign head = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      dropped <= 1'b0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
      if (push_req && full) dropped <= 1'b1;
    end
  end

endmodule

// File: rtl/rs485tx_serializer.sv
module rs485tx_serializer #(
  parameter int DATA_W = 8,
  localparam int FRAME_BITS = DATA_W + 2,
  localparam int BIT_W = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [15:0]       bit_cycles,
  output logic              txd,
  output logic              active,
  output logic              frame_end
);
  import rs485tx_pkg::*;

  logic [FRAME_BITS-1:0] shreg;
  logic [15:0]           cyc_q;
  logic [BIT_W-1:0]      bit_q;
  logic                  bit_end;

  assign bit_end   = active && (cyc_q == last_bit_cycle(bit_cycles));
  assign frame_end = bit_end && (bit_q == BIT_W'(FRAME_BITS - 1));
  assign txd       = !active || shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      shreg  <= '1;
      cyc_q  <= '0;
      bit_q  <= '0;
    end else if (load) begin
      active <= 1'b1;
      shreg  <= {1'b1, load_data, 1'b0};
      cyc_q  <= '0;
      bit_q  <= '0;
    end else if (active) begin
      if (bit_end) begin
        cyc_q <= '0;
        if (frame_end) begin
          active <= 1'b0;
        end else begin
          bit_q <= bit_q + BIT_W'(1);
          shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
        end
      end else begin
        cyc_q <= cyc_q + 16'd1;
      end
    end
  end

endmodule

// File: rtl/rs485tx_dirctl.sv
module rs485tx_dirctl #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             has_data,
  input  logic             frame_end,
  input  logic [DLY_W-1:0] lead_delay,
  input  logic [DLY_W-1:0] trail_delay,
  output logic             load,
  output logic             dir_en
);
  import rs485tx_pkg::*;

  dir_state_e       state;
  logic [DLY_W-1:0] cnt;

  assign dir_en = (state != DIR_IDLE);
  assign load   = ((state == DIR_LEAD)  && (cnt == lead_delay))
               || ((state == DIR_RUN)   && frame_end && has_data)
               || ((state == DIR_TRAIL) && has_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= DIR_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        DIR_IDLE: if (has_data) begin
          state <= DIR_LEAD;
          cnt   <= '0;
        end
        DIR_LEAD: if (cnt == lead_delay) state <= DIR_RUN;
                  else cnt <= cnt + DLY_W'(1);
        DIR_RUN: if (frame_end && !has_data) begin
          state <= DIR_TRAIL;
          cnt   <= '0;
        end
        DIR_TRAIL: if (has_data) state <= DIR_RUN;
                   else if (cnt == trail_delay) state <= DIR_IDLE;
                   else cnt <= cnt + DLY_W'(1);
        default: state <= DIR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rs485_uart_tx.sv
module rs485_uart_tx #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int THRESH = 32,
  parameter int DLY_W  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              overflow,
  input  logic [15:0]       bit_cycles,
  input  logic [DLY_W-1:0]  lead_delay,
  input  logic [DLY_W-1:0]  trail_delay,
  input  logic              empty_irq_mode,
  input  logic              irq_enable,
  output logic              irq,
  output logic              tx_done,
  output logic              txd,
  output logic              dir_en
);
  import rs485tx_pkg::*;

  logic [DATA_W-1:0] head;
  logic              load, ser_active, frame_end, has_data;

  assign has_data = (fifo_level != '0);

  rs485tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_req(wr_en), .push_data(wr_data),
    .pop(load), .head(head), .level(fifo_level), .dropped(overflow)
  );

  rs485tx_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(head),
    .bit_cycles(bit_cycles), .txd(txd), .active(ser_active),
    .frame_end(frame_end)
  );

  rs485tx_dirctl #(.DLY_W(DLY_W)) u_dir (
    .clk(clk), .rst_n(rst_n), .has_data(has_data), .frame_end(frame_end),
    .lead_delay(lead_delay), .trail_delay(trail_delay),
    .load(load), .dir_en(dir_en)
  );

  assign irq = irq_enable && irq_request(empty_irq_mode, !has_data,
                                         fifo_level <= LVL_W'(THRESH),
                                         ser_active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  tx_done <= 1'b1;
    else if (wr_en)              tx_done <= 1'b0;
    else if (frame_end && !load) tx_done <= 1'b1;
  end

endmodule

// File: rtl/rs485_uart_tx_chk.sv
module rs485_uart_tx_chk #(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             txd,
  input logic             dir_en,
  input logic             irq,
  input logic             empty_irq_mode,
  input logic             tx_done,
  input logic             overflow,
  input logic [LVL_W-1:0] fifo_level,
  input logic             ser_active
);

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_dir_before_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> $past(dir_en));

  assert_low_needs_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !txd |-> dir_en);

  assert_release_on_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dir_en) |-> (txd && !ser_active));

  assert_drained_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && empty_irq_mode) |-> (txd && fifo_level == '0));

  assert_write_clears_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tx_done);

endmodule

bind rs485_uart_tx rs485_uart_tx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .txd(txd), .dir_en(dir_en),
  .irq(irq), .empty_irq_mode(empty_irq_mode), .tx_done(tx_done),
  .overflow(overflow), .fifo_level(fifo_level), .ser_active(ser_active)
);

// File: tb/rs485_uart_tx_tb.sv
module rs485_uart_tx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        wr_en = 1'b0;
  logic [6:0]  fifo_level;
  logic        overflow;
  logic [15:0] bit_cycles = 16'd2;
  logic [15:0] lead_delay = 16'd0;
  logic [15:0] trail_delay = 16'd0;
  logic        empty_irq_mode = 1'b0;
  logic        irq_enable = 1'b1;
  logic        irq, tx_done, txd, dir_en;

  always #4 clk = ~clk;

  rs485_uart_tx u_dut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en(wr_en),
    .fifo_level(fifo_level), .overflow(overflow), .bit_cycles(bit_cycles),
    .lead_delay(lead_delay), .trail_delay(trail_delay),
    .empty_irq_mode(empty_irq_mode), .irq_enable(irq_enable), .irq(irq),
    .tx_done(tx_done), .txd(txd), .dir_en(dir_en)
  );

  int checks = 0, errors = 0, mon_checks = 0, mon_errs = 0;
  int cyc = 0;
  bit done_flag = 0;

  // Line decoder and event recorder
  bit        dec_busy = 0, dir_prev = 0;
  int        rx_cnt = 0, rx_ebc = 1, rx_t0 = 0, rx_n = 0;
  logic [7:0] rx_sh = 8'h00;
  logic [7:0] rx_bytes [0:255];
  int        rx_start [0:255];
  int        dir_rise_t = 0, dir_fall_t = 0, dir_falls = 0;

  always @(negedge clk) begin
    bit exp_act, exp_irq;
    if (!rst_n) begin
      dec_busy = 0;
      dir_prev = 0;
    end else begin
      cyc++;
      exp_act = dec_busy || !txd;
      exp_irq = irq_enable && (empty_irq_mode ? (fifo_level == 0 && !exp_act)
                                              : (fifo_level <= 7'd32));
      mon_checks++;
      if (irq !== exp_irq) begin
        mon_errs++;
        $display("FAIL R5/R6/R7 irq at cycle %0d actual %0d expected %0d", cyc, irq, exp_irq);
      end
      mon_checks++;
      if (!txd && !dir_en) begin
        mon_errs++;
        $display("FAIL R9 line low without driver actual dir_en %0d expected 1", dir_en);
      end
      if (dir_en && !dir_prev) dir_rise_t = cyc;
      if (!dir_en && dir_prev) begin
        dir_fall_t = cyc;
        dir_falls++;
      end
      dir_prev = dir_en;
      if (!dec_busy) begin
        if (!txd) begin
          dec_busy = 1;
          rx_cnt = 0;
          rx_t0 = cyc;
          rx_ebc = (bit_cycles == 0) ? 1 : int'(bit_cycles);
        end
      end else begin
        rx_cnt++;
        if (rx_cnt % rx_ebc == 0 && rx_cnt / rx_ebc >= 1 && rx_cnt / rx_ebc <= 8)
          rx_sh[rx_cnt / rx_ebc - 1] = txd;
        if (rx_cnt == 9 * rx_ebc) begin
          mon_checks++;
          if (!txd) begin
            mon_errs++;
            $display("FAIL R2 stop bit actual %0d expected 1", txd);
          end
        end
        if (rx_cnt == 10 * rx_ebc - 1) begin
          rx_bytes[rx_n] = rx_sh;
          rx_start[rx_n] = rx_t0;
          rx_n++;
          dec_busy = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errs);
      $finish;
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1;
    wr_data = d;
    wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (dir_en || fifo_level != 0 || dec_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected 0", 1);
    report();
  end

  initial begin
    int n0, f0, ebc, bad;
    logic [7:0] pat;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1,       "R1 txd",       txd, 1);
    chk(dir_en == 1'b0,    "R1 dir_en",    dir_en, 0);
    chk(tx_done == 1'b1,   "R1 tx_done",   tx_done, 1);
    chk(fifo_level == 0,   "R1 level",     fifo_level, 0);
    chk(overflow == 1'b0,  "R1 overflow",  overflow, 0);
    chk(irq == 1'b1,       "R5 irq empty", irq, 1);

    // Sweep of bit time and guard intervals (R2, R8, R9, R11)
    for (int b = 0; b < 3; b++) begin
      for (int l = 0; l < 2; l++) begin
        for (int t = 0; t < 2; t++) begin
          @(posedge clk); #1;
          bit_cycles  = (b == 0) ? 16'd0 : ((b == 1) ? 16'd1 : 16'd3);
          lead_delay  = 16'(l * 2);
          trail_delay = 16'(t * 3);
          ebc = (b == 2) ? 3 : 1;
          pat = 8'hA5 ^ 8'((b * 4 + l * 2 + t) * 37);
          n0 = rx_n;
          f0 = dir_falls;
          wr(pat);
          wait_idle();
          chk(rx_n == n0 + 1, "R2 frame count", rx_n, n0 + 1);
          chk(rx_bytes[n0] == pat, "R2 data", rx_bytes[n0], pat);
          chk(rx_start[n0] - dir_rise_t == l * 2 + 1, "R8 lead",
              rx_start[n0] - dir_rise_t, l * 2 + 1);
          chk(dir_fall_t - (rx_start[n0] + 10 * ebc) == t * 3 + 1, "R9 trail",
              dir_fall_t - (rx_start[n0] + 10 * ebc), t * 3 + 1);
          chk(dir_falls == f0 + 1, "R9 single release", dir_falls, f0 + 1);
          chk(tx_done == 1'b1, "R11 done after frame", tx_done, 1);
        end
      end
    end

    // Burst: no idle gap between frames (R4)
    @(posedge clk); #1;
    bit_cycles = 16'd2; lead_delay = 16'd1; trail_delay = 16'd2;
    n0 = rx_n; f0 = dir_falls;
    @(posedge clk); #1;
    wr_en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      wr_data = 8'h3C ^ 8'(k << 3);
      @(posedge clk); #1;
    end
    wr_en = 1'b0;
    @(negedge clk);
    chk(tx_done == 1'b0, "R11 cleared by write", tx_done, 0);
    wait_idle();
    chk(rx_n == n0 + 5, "R4 burst count", rx_n, n0 + 5);
    bad = 0;
    for (int k = 0; k < 5; k++) if (rx_bytes[n0 + k] != (8'h3C ^ 8'(k << 3))) bad++;
    chk(bad == 0, "R4 burst order", bad, 0);
    for (int k = 1; k < 5; k++)
      chk(rx_start[n0 + k] - rx_start[n0 + k - 1] == 20, "R4 gapless",
          rx_start[n0 + k] - rx_start[n0 + k - 1], 20);
    chk(dir_falls == f0 + 1, "R4 one release", dir_falls, f0 + 1);

    // Write during trailing interval (R10)
    @(posedge clk); #1;
    lead_delay = 16'd0; trail_delay = 16'd30;
    n0 = rx_n; f0 = dir_falls;
    wr(8'h5A);
    while (rx_n == n0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(dir_en == 1'b1, "R10 held in trail", dir_en, 1);
    wr(8'hC3);
    wait_idle();
    chk(dir_falls == f0 + 1, "R10 no release", dir_falls, f0 + 1);
    chk(rx_n == n0 + 2, "R10 second frame", rx_n, n0 + 2);
    chk(rx_bytes[n0 + 1] == 8'hC3, "R10 data", rx_bytes[n0 + 1], 8'hC3);

    // Mode switching (R5, R6, R7)
    @(posedge clk); #1;
    bit_cycles = 16'd20; trail_delay = 16'd0;
    @(posedge clk); #1;
    wr_en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      wr_data = 8'(k);
      @(posedge clk); #1;
    end
    wr_en = 1'b0;
    @(negedge clk);
    chk(irq == 1'b1, "R5 under threshold", irq, 1);
    @(posedge clk); #1 empty_irq_mode = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R6 drained mode busy", irq, 0);
    @(posedge clk); #1 empty_irq_mode = 1'b0;
    @(negedge clk);
    chk(irq == 1'b1, "R7 reassert on clear", irq, 1);
    @(posedge clk); #1 empty_irq_mode = 1'b1;
    wait_idle();
    chk(irq == 1'b1, "R6 drained", irq, 1);
    @(posedge clk); #1 irq_enable = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R7 enable off", irq, 0);
    @(posedge clk); #1 irq_enable = 1'b1; empty_irq_mode = 1'b0;

    // Overflow flood (R3, R4, R5)
    n0 = rx_n;
    @(posedge clk); #1;
    wr_en = 1'b1;
    for (int k = 0; k < 70; k++) begin
      wr_data = 8'(k);
      @(posedge clk); #1;
    end
    wr_en = 1'b0;
    @(negedge clk);
    chk(fifo_level == 64, "R3 full level", fifo_level, 64);
    chk(overflow == 1'b1, "R3 overflow set", overflow, 1);
    chk(irq == 1'b0, "R5 above threshold", irq, 0);
    while (fifo_level == 64) @(negedge clk);
    chk(fifo_level == 63, "R4 one per frame", fifo_level, 63);
    while (fifo_level > 32) @(negedge clk);
    chk(irq == 1'b1, "R5 at threshold", irq, 1);
    wait_idle();
    chk(rx_n == n0 + 65, "R3 kept count", rx_n, n0 + 65);
    bad = 0;
    for (int k = 0; k < 65; k++) if (rx_bytes[n0 + k] != 8'(k)) bad++;
    chk(bad == 0, "R3 drop not overwrite", bad, 0);
    chk(overflow == 1'b1, "R3 sticky", overflow, 1);
    chk(tx_done == 1'b1, "R11 done after flood", tx_done, 1);

    report();
  end

endmodule